// File: doc/BRIEF.md
# Prescaled Up/Down/Center-Aligned Timer Counter

This block is a single timer counter with a programmable prescaler in front of it. The prescaler divides the system clock by PSC+1. Each divided tick moves a counter that can run in one of three shapes: a rising sawtooth, a falling sawtooth, or a triangle that rises to the reload value and falls back to zero. Each time the counter crosses a boundary it raises a one-cycle update strobe, and that strobe sets a sticky update flag. Software clears the flag through a dedicated clear input.

Software controls the block through four write ports: an 8-bit control word, the prescaler value, the reload value, and a direct load of the counter. The reload value can be double-buffered so that a new value waits for the next update. The prescaler value is always double-buffered, so a running period is never cut short. A single-shot setting runs the counter for exactly one period and then clears the enable bit by itself. A software load of the counter can also serve as a forced update, which copies the buffered values into the active ones.

Top module: `tmr_core`

## Requirements
- R1: After a synchronous reset, the count, the control word, the update strobe, the update flag and the direction output are all zero. The active prescaler and reload values are also zero.
- R2: While enable (control bit 0) is 1, the counter moves once every PSC+1 clock cycles. While enable is 0, the counter and the prescaler hold their values.
- R3: With cms (control bits 5:4) = 0 and dir (control bit 7) = 0, the counter counts up from 0 to the reload value and then wraps to 0 with an update event. Update events are then spaced (PSC+1)*(ARR+1) cycles apart.
- R4: With cms = 0 and dir = 1, the counter counts down to 0 and then reloads the reload value with an update event. The count shown together with the strobe equals the reload value, and events are spaced (PSC+1)*(ARR+1) cycles apart.
- R5: With cms nonzero, the counter rises to the reload value and then falls to 0, raising an update event at both turning points. Events are spaced (PSC+1)*ARR cycles apart. `dir_o` reads 0 while the counter rises and 1 while it falls.
- R6: With the single-shot bit (control bit 6) set, the counter stops after one full period and enable clears by itself. In edge modes the counter stops at the wrap value; in center mode it stops at 0 with `dir_o` = 0.
- R7: With arpe (control bit 3) = 1, a new reload value takes effect only at the next update event. With arpe = 0 it takes effect on the next counter step.
- R8: A new prescaler value takes effect only at the next update event, so the period in progress keeps its old length.
- R9: With udis (control bit 1) = 1, no update strobe is produced, the flag is not set, and the buffered values are not copied. The counter still wraps at the active reload value.
- R10: A write to the counter loads it in the next cycle and restarts the prescaler, so the next step comes PSC+1 cycles later. The write counts as an update event only when urs (control bit 2) = 0 and udis = 0.
- R11: `uif_o` is set by every update event and stays set until `uif_clr` is pulsed. If an event and a clear arrive in the same cycle, the set wins.
- R12: The control word reads back on `ctl_q` exactly as written, with bit 0 enable, bit 1 udis, bit 2 urs, bit 3 arpe, bits 5:4 cms, bit 6 single-shot, bit 7 dir. In edge modes `dir_o` shows bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| psc_we | input | 1 | Prescaler value write strobe |
| psc_wdata | input | PSC_W | Prescaler value (divide by value+1) |
| arr_we | input | 1 | Reload value write strobe |
| arr_wdata | input | CNT_W | Reload value |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| uif_clr | input | 1 | Clears the update flag |
| ctl_q | output | 8 | Current control word, including the self-cleared enable |
| cnt_o | output | CNT_W | Current count |
| upd_o | output | 1 | One-cycle update event strobe |
| dir_o | output | 1 | Current counting direction (1 = down) |
| uif_o | output | 1 | Sticky update flag |

## Verification
The hardest conditions to reach are the ones where buffered state is supposed to stay untouched while events are suppressed. Examples are a reload value written while udis is set, or a prescaler change made in the middle of a period. None of these can be read directly from the ports. To reach them, the stimulus writes the new value right at an update strobe, then measures the spacing of the next two strobes, or the peak count reached while events are masked. A forced update through a counter write with urs clear is used to load a prescaler value at a known instant. A behavioural model in the bench follows every clock, so single-shot stops and mode changes are compared cycle by cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic       dir;
    logic       opm;
    logic [1:0] cms;
    logic       arpe;
    logic       urs;
    logic       udis;
    logic       cen;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             reload,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  output logic             tick
);
  logic [PSC_W-1:0] psc_pend;
  logic [PSC_W-1:0] psc_act;
  logic [PSC_W-1:0] pcnt;

  assign tick = run && (pcnt == psc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_pend <= '0;
      psc_act  <= '0;
      pcnt     <= '0;
    end else begin
      if (reload) psc_act <= psc_pend;
      if (psc_we) psc_pend <= psc_wdata;
      if (restart)  pcnt <= '0;
      else if (run) pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end

  AST_PSC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(pcnt)); // R2
  AST_PSC_BOUND: assert property (@(posedge clk) disable iff (rst)
    pcnt <= psc_act); // R8
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             center,
  input  logic             down,
  input  logic             opm,
  input  logic [CNT_W-1:0] arr_eff,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             dq,
  output logic             wrap,
  output logic             stop
);
  logic [CNT_W-1:0] nxt;
  logic             nd;
  logic             edge_hit;

  always_comb begin
    nxt      = cnt;
    nd       = dq;
    edge_hit = 1'b0;
    if (!center) begin
      nd = 1'b0;
      if (!down) begin
        if (cnt >= arr_eff) begin edge_hit = 1'b1; nxt = '0; end
        else nxt = cnt + 1'b1;
      end else begin
        if (cnt == '0) begin edge_hit = 1'b1; nxt = arr_eff; end
        else nxt = cnt - 1'b1;
      end
    end else if (!dq) begin
      if (cnt >= arr_eff) begin
        edge_hit = 1'b1;
        nd       = 1'b1;
        nxt      = (cnt == '0) ? '0 : cnt - 1'b1;
      end else nxt = cnt + 1'b1;
    end else begin
      if (cnt == '0) begin
        edge_hit = 1'b1;
        nd       = 1'b0;
        nxt      = (opm || arr_eff == '0) ? '0 : CNT_W'(1);
      end else nxt = cnt - 1'b1;
    end
  end

  assign wrap = tick && edge_hit;
  assign stop = wrap && opm && (!center || dq);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dq  <= 1'b0;
    end else if (ld) begin
      cnt <= ld_val;
      dq  <= center ? dq : 1'b0;
    end else if (tick) begin
      cnt <= nxt;
      dq  <= nd;
    end else begin
      dq  <= center ? dq : 1'b0;
    end
  end

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !center && !down && cnt < arr_eff) |=> cnt == $past(cnt) + 1'b1); // R3
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !center && down && cnt == '0) |=> cnt == $past(arr_eff)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld && center) |=> $stable(dq)); // R5
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             uif_clr,
  output logic [7:0]       ctl_q,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             dir_o,
  output logic             uif_o
);
  tmr_ctl_t         ctl;
  logic [CNT_W-1:0] arr_pend;
  logic [CNT_W-1:0] arr_act;
  logic [CNT_W-1:0] arr_eff;
  logic             center;
  logic             tick;
  logic             wrap;
  logic             stop;
  logic             dq;
  logic             upd_ev;

  assign center  = (ctl.cms != 2'b00);
  assign arr_eff = ctl.arpe ? arr_act : arr_pend;
  assign upd_ev  = !ctl.udis && (wrap || (cnt_we && !ctl.urs));

  tmr_presc #(.PSC_W(PSC_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .run      (ctl.cen),
    .restart  (cnt_we),
    .reload   (upd_ev),
    .psc_we   (psc_we),
    .psc_wdata(psc_wdata),
    .tick     (tick)
  );

  tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .center (center),
    .down   (ctl.dir),
    .opm    (ctl.opm),
    .arr_eff(arr_eff),
    .ld     (cnt_we),
    .ld_val (cnt_wdata),
    .cnt    (cnt_o),
    .dq     (dq),
    .wrap   (wrap),
    .stop   (stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      arr_pend <= '0;
      arr_act  <= '0;
      upd_o    <= 1'b0;
      uif_o    <= 1'b0;
    end else begin
      if (ctl_we)    ctl     <= tmr_ctl_t'(ctl_wdata);
      else if (stop) ctl.cen <= 1'b0;
      if (upd_ev) arr_act  <= arr_pend;
      if (arr_we) arr_pend <= arr_wdata;
      upd_o <= upd_ev;
      if (upd_ev)       uif_o <= 1'b1;
      else if (uif_clr) uif_o <= 1'b0;
    end
  end

  assign ctl_q = ctl;
  assign dir_o = center ? dq : ctl.dir;

  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> uif_o); // R11
  AST_UDIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> !$past(ctl.udis)); // R9
  AST_OPM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctl.cen) && !$past(ctl_we)) |-> $past(ctl.opm)); // R6
endmodule

// File: tb/tmr_core_tb.sv
module tmr_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 0, psc_we = 0, arr_we = 0, cnt_we = 0, uif_clr = 0;
  logic [7:0]  ctl_wd = 0;
  logic [15:0] psc_wd = 0;
  logic [31:0] arr_wd = 0, cnt_wd = 0;
  logic [7:0]  ctl_q;
  logic [31:0] cnt_o;
  logic        upd_o, dir_o, uif_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_core u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wd),
    .psc_we(psc_we), .psc_wdata(psc_wd), .arr_we(arr_we), .arr_wdata(arr_wd),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wd), .uif_clr(uif_clr),
    .ctl_q(ctl_q), .cnt_o(cnt_o), .upd_o(upd_o), .dir_o(dir_o), .uif_o(uif_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_ctl;
  logic [15:0] m_pscp, m_psca, m_pc;
  logic [31:0] m_arrp, m_arra, m_cnt;
  logic        m_dq, m_upd, m_uif;

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 0; m_pscp = 0; m_psca = 0; m_pc = 0; m_arrp = 0; m_arra = 0;
      m_cnt = 0; m_dq = 0; m_upd = 0; m_uif = 0;
    end else begin : step
      logic cen, udis, urs, arpe, ctr, opm, dn, tick, edg, ev, stop, nd;
      logic [31:0] ae, nc;
      cen = m_ctl[0]; udis = m_ctl[1]; urs = m_ctl[2]; arpe = m_ctl[3];
      ctr = (m_ctl[5:4] != 0); opm = m_ctl[6]; dn = m_ctl[7];
      ae = arpe ? m_arra : m_arrp;
      tick = cen && (m_pc == m_psca);
      edg = 0; nc = m_cnt; nd = m_dq;
      if (!ctr && !dn) begin
        if (m_cnt >= ae) begin edg = 1; nc = 0; end else nc = m_cnt + 1;
      end else if (!ctr) begin
        if (m_cnt == 0) begin edg = 1; nc = ae; end else nc = m_cnt - 1;
      end else if (!m_dq) begin
        if (m_cnt >= ae) begin edg = 1; nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else nc = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin edg = 1; nd = 0; nc = (opm || ae == 0) ? 0 : 1; end
        else nc = m_cnt - 1;
      end
      edg  = edg && tick;
      stop = edg && opm && (!ctr || m_dq);
      ev   = !udis && (edg || (cnt_we && !urs));
      if (ev) begin m_arra = m_arrp; m_psca = m_pscp; end
      if (arr_we) m_arrp = arr_wd;
      if (psc_we) m_pscp = psc_wd;
      if (cnt_we) m_pc = 0; else if (cen) m_pc = tick ? 16'd0 : m_pc + 16'd1;
      if (!ctr) m_dq = 0;
      if (cnt_we) m_cnt = cnt_wd;
      else if (tick) begin m_cnt = nc; if (ctr) m_dq = nd; end
      if (ctl_we) m_ctl = ctl_wd; else if (stop) m_ctl[0] = 0;
      m_uif = ev ? 1'b1 : (uif_clr ? 1'b0 : m_uif);
      m_upd = ev;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      string mt;
      mt = (m_ctl[5:4] != 0) ? "R5 count" : (m_ctl[7] ? "R4 count" : "R3 count");
      chk(mt, cnt_o, m_cnt);
      chk("R3 strobe", {31'd0, upd_o}, {31'd0, m_upd});
      chk("R5 direction", {31'd0, dir_o}, {31'd0, (m_ctl[5:4] != 0) ? m_dq : m_ctl[7]});
      chk("R11 flag", {31'd0, uif_o}, {31'd0, m_uif});
      chk("R6 control", {24'd0, ctl_q}, {24'd0, m_ctl});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=expired exp=finished");
    finish_sim();
  end

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wd = v; @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_psc(input logic [15:0] v);
    psc_we = 1; psc_wd = v; @(negedge clk); psc_we = 0;
  endtask
  task automatic wr_arr(input logic [31:0] v);
    arr_we = 1; arr_wd = v; @(negedge clk); arr_we = 0;
  endtask
  task automatic wr_cnt(input logic [31:0] v);
    cnt_we = 1; cnt_wd = v; @(negedge clk); cnt_we = 0;
  endtask
  task automatic clr_flag();
    uif_clr = 1; @(negedge clk); uif_clr = 0;
  endtask
  task automatic wait_upd();
    do @(negedge clk); while (!upd_o);
  endtask
  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_o);
  endtask

  initial begin
    int n;
    logic [31:0] v, mx;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 count", cnt_o, 0);
    chk("R1 control", {24'd0, ctl_q}, 0);
    chk("R1 flag", {30'd0, upd_o, uif_o}, 0);
    chk("R1 direction", {31'd0, dir_o}, 0);

    // R10 forced update loads prescaler 1 and reload 4
    wr_psc(16'd1);
    wr_arr(32'd4);
    wr_cnt(32'd0);
    chk("R10 forced update strobe", {31'd0, upd_o}, 1);
    chk("R11 flag set", {31'd0, uif_o}, 1);
    clr_flag();
    chk("R11 flag cleared", {31'd0, uif_o}, 0);

    // R3 up counting period
    wr_ctl(8'h01);
    chk("R12 readback", {24'd0, ctl_q}, 32'h01);
    wait_upd();
    chk("R3 wrap value", cnt_o, 0);
    measure(n);
    chk("R3 period", n, 10);

    // R2 hold when disabled
    wr_ctl(8'h00);
    v = cnt_o;
    repeat (10) @(negedge clk);
    chk("R2 hold", cnt_o, v);

    // R4 down counting
    wr_ctl(8'h81);
    chk("R12 dir bit", {31'd0, dir_o}, 1);
    wait_upd();
    chk("R4 reload on strobe", cnt_o, 4);
    measure(n);
    chk("R4 period", n, 10);

    // R8 prescaler buffered
    wr_psc(16'd0);
    measure(n);
    chk("R8 old period kept", n, 9);
    measure(n);
    chk("R8 new period", n, 5);

    // R7 reload buffered with arpe
    wr_ctl(8'h09);
    wait_upd();
    wr_arr(32'd9);
    measure(n);
    chk("R7 held reload", n, 4);
    measure(n);
    chk("R7 new reload", n, 10);
    wr_ctl(8'h01);
    wait_upd();
    wr_arr(32'd2);
    measure(n);
    measure(n);
    chk("R7 immediate reload", n, 3);

    // R5 center aligned
    wr_arr(32'd5);
    wr_ctl(8'h11);
    wait_upd();
    for (int i = 0; i < 3; i++) begin
      v = {31'd0, dir_o};
      measure(n);
      chk("R5 half period", n, 5);
      chk("R5 direction flips", {31'd0, dir_o}, v ^ 1);
    end

    // R9 update disable: no strobe, no flag, no shadow copy
    wr_ctl(8'h0B);
    clr_flag();
    wr_arr(32'd2);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cnt_o > mx) mx = cnt_o;
      if (upd_o || uif_o) chk("R9 quiet", {30'd0, upd_o, uif_o}, 0);
    end
    chk("R9 flag stays clear", {31'd0, uif_o}, 0);
    chk("R9 active reload kept", mx, 5);
    wr_ctl(8'h09);
    wait_upd();
    measure(n);
    chk("R9 reload copied after enable", n, 3);

    // R10 load with urs set, prescaler restart
    wr_psc(16'd3);
    wr_ctl(8'h01);
    wr_cnt(32'd0);
    wr_ctl(8'h05);
    repeat (2) @(negedge clk);
    wr_cnt(32'd1);
    chk("R10 load value", cnt_o, 1);
    chk("R10 no strobe with urs", {31'd0, upd_o}, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (cnt_o == 1 && n < 20);
    chk("R10 prescaler restart", n, 4);

    // R11 set wins over clear
    uif_clr = 1;
    wr_ctl(8'h01);
    cnt_we = 1; cnt_wd = 0; @(negedge clk); cnt_we = 0; uif_clr = 0;
    chk("R11 set wins", {31'd0, uif_o}, 1);
    clr_flag();

    // R6 single shot, edge mode
    wr_ctl(8'h41);
    n = 0;
    while (ctl_q[0] && n < 200) begin @(negedge clk); n++; end
    chk("R6 enable cleared", {24'd0, ctl_q}, 32'h40);
    chk("R6 stop value", cnt_o, 0);
    repeat (20) @(negedge clk);
    chk("R6 stays stopped", cnt_o, 0);

    // R6 single shot, center mode
    wr_ctl(8'h51);
    n = 0;
    while (ctl_q[0] && n < 400) begin @(negedge clk); n++; end
    chk("R6 center enable cleared", {24'd0, ctl_q}, 32'h50);
    chk("R6 center stop value", cnt_o, 0);
    chk("R6 center direction", {31'd0, dir_o}, 0);
    repeat (10) @(negedge clk);
    chk("R6 center stays", cnt_o, 0);

    finish_sim();
  end
endmodule